// File: doc/BRIEF.md
# HDLC/SDLC Transmit Framer with Zero Insertion

This block turns bytes handed over through a one-byte holding buffer into a bit-oriented HDLC/SDLC serial stream. While no frame is open, it sends the flag pattern continuously. Once a byte waits in the buffer, the byte goes out least significant bit first, and a 16-bit CCITT frame check is accumulated over the frame's data bits. When the buffer is found empty at a unit boundary while a frame is open, the frame closes by itself: the inverted check value is sent, followed by flags. Data and check bits pass through zero insertion. A 0 is added after every run of five 1s, and the run is counted across byte borders and from the last data byte into the check field. Flags are never stuffed.

Software or a DMA engine writes a byte each time the buffer-empty indication or the transmit interrupt shows that room is free. A byte written before the transmitter is switched on becomes the first unit sent, in place of an opening flag. One bit leaves per cycle in which the bit-rate enable is high. The transmitter runs only while it is enabled and, when automatic enabling is selected, while the clear-to-send input is low.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, txd is 1, bufEmpty is 1, txIntPend is 0 and eomStatus is 0.
- R2: While active with an empty buffer and no frame open, the framer sends back-to-back flags 0x7E (bit sequence 0,1,1,1,1,1,1,0). Flag bits are never stuffed, and they reset the count of consecutive ones.
- R3: Bytes are sent least significant bit first. A new unit is chosen only at a unit boundary. A byte written while the transmitter is off is the first unit sent once it is on, with no flag ahead of it.
- R4: After five consecutive 1s drawn from data or check bits, a single 0 is inserted, and that 0 consumes a bit tick. The count runs across byte boundaries and from data into the check field.
- R5: At a unit boundary with an empty buffer and an open frame, the framer sends the 16-bit check value and then returns to flags. The check value is the ones complement of the CRC with polynomial x^16+x^12+x^5+1, preset to 0xFFFF and shifted reflected (LSB first), and its low bit is sent first. eomStatus sets when the check field starts and clears when the next frame's first byte is loaded. Running the CRC over the data and the check field gives the residue 0xF0B8.
- R6: For the nine ASCII bytes "123456789", the check value sent is 0x906E.
- R7: A write clears bufEmpty on the next cycle. Moving the byte into the shifter sets bufEmpty and txIntPend. txIntPend clears on a write or on intClr, and a new event wins over intClr. A write in the same cycle as a move keeps the buffer full, raises no interrupt, and the old byte is the one sent.
- R8: Writing to a full buffer replaces the waiting byte.
- R9: The transmitter is active when txEnable && (!autoEnable || !ctsN). While it is inactive, bit ticks are ignored, txd is driven to 1, the buffer is not taken, and the position inside the current unit is kept.
- R10: txd changes only on a cycle with bitEn high while active, and it sends one bit per such tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the holding buffer |
| wrData | input | 8 | Byte to transmit |
| intClr | input | 1 | Command that clears the transmit interrupt |
| txEnable | input | 1 | Transmitter enable |
| autoEnable | input | 1 | Require ctsN low to transmit |
| ctsN | input | 1 | Clear-to-send, active low |
| bitEn | input | 1 | Bit-rate enable, one bit per high cycle |
| txd | output | 1 | Serial data out |
| bufEmpty | output | 1 | Holding buffer is empty |
| txIntPend | output | 1 | Transmit interrupt pending |
| eomStatus | output | 1 | Check field appended, frame closed |

## Verification
The buffer write and the move of the waiting byte into the shifter can fall in the same cycle. When they do, the old byte must be sent, the new one must stay waiting, and no interrupt may be raised. The bench provokes this with a long stretch of dense pseudo-random writes against random bit ticks and clear-to-send gaps. A behavioural model judges every cycle: it queues unit bits and resolves the write after the load. The bench counts how often the two coincide and requires that this happens at least once. A second overlap is a stuffed zero due right at a unit boundary; it is judged the same way.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  // kind of unit now in the shifter
  typedef enum logic [1:0] {UNIT_FLAG, UNIT_DATA, UNIT_FCS} unitKind_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic idleMark;   // transmitter gated off: drive mark
    logic emitStuff;  // send inserted zero, position held
    logic loadData;   // take buffer byte, send its first bit
    logic loadFcs;    // take inverted check, send its first bit
    logic loadFlag;   // take flag, send its first bit
    logic shiftOut;   // send next bit of current unit
    logic crcStep;    // fold the bit sent into the check
    logic crcPreset;  // start a new check before folding
  } txStrobe_t;
endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CRC_W     = 16,
  parameter int STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       autoEnable,
  input  logic       ctsN,
  input  logic       bitEn,
  input  logic       wrEn,
  input  logic       intClr,
  input  logic       outBit,
  output txStrobe_t  strb,
  output logic       bufEmpty,
  output logic       txIntPend,
  output logic       eomStatus
);
  localparam int CNT_W = $clog2(CRC_W + 1);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FCS_LAST  = CNT_W'(CRC_W - 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(STUFF_RUN);

  logic [CNT_W-1:0] bitsLeft;
  logic [RUN_W-1:0] onesRun;
  unitKind_t        unit;
  logic             inFrame, bufFull, intPend, eomReg;
  logic             active, tick, bitSent, bitStuffable, fcsLoad;

  always_comb begin
    active = txEnable & (~autoEnable | ~ctsN);
    tick   = active & bitEn;
    strb   = '0;
    strb.idleMark = ~active;
    if (tick) begin
      if (onesRun == RUN_MAX) begin
        strb.emitStuff = 1'b1;
      end else if (bitsLeft == '0) begin
        if (bufFull) begin
          strb.loadData  = 1'b1;
          strb.crcStep   = 1'b1;
          strb.crcPreset = ~inFrame;
        end else if (inFrame) begin
          strb.loadFcs = 1'b1;
        end else begin
          strb.loadFlag = 1'b1;
        end
      end else begin
        strb.shiftOut = 1'b1;
        strb.crcStep  = (unit == UNIT_DATA);
      end
    end
    bitSent      = strb.loadData | strb.loadFcs | strb.loadFlag | strb.shiftOut;
    bitStuffable = strb.loadData | strb.loadFcs | (strb.shiftOut & (unit != UNIT_FLAG));
    fcsLoad      = strb.loadFcs;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitsLeft <= '0;
      unit     <= UNIT_FLAG;
      onesRun  <= '0;
      inFrame  <= 1'b0;
      bufFull  <= 1'b0;
      intPend  <= 1'b0;
      eomReg   <= 1'b0;
    end else begin
      if (strb.loadData) begin
        bitsLeft <= DATA_LAST;
        unit     <= UNIT_DATA;
        inFrame  <= 1'b1;
      end else if (strb.loadFcs) begin
        bitsLeft <= FCS_LAST;
        unit     <= UNIT_FCS;
        inFrame  <= 1'b0;
      end else if (strb.loadFlag) begin
        bitsLeft <= DATA_LAST;
        unit     <= UNIT_FLAG;
      end else if (strb.shiftOut) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
      end

      if (strb.emitStuff)
        onesRun <= '0;
      else if (bitSent)
        onesRun <= (bitStuffable && outBit) ? onesRun + RUN_W'(1) : '0;

      if (wrEn)
        bufFull <= 1'b1;
      else if (strb.loadData)
        bufFull <= 1'b0;

      if (strb.loadData && !wrEn)
        intPend <= 1'b1;
      else if (wrEn || intClr)
        intPend <= 1'b0;

      if (strb.loadFcs)
        eomReg <= 1'b1;
      else if (strb.loadData && !inFrame)
        eomReg <= 1'b0;
    end
  end

  assign bufEmpty  = ~bufFull;
  assign txIntPend = intPend;
  assign eomStatus = eomReg;

  // R4
  run_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    onesRun <= RUN_MAX);
  // R7
  empty_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> txIntPend);
  // R7
  write_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !bufEmpty);
  // R5
  eom_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eomStatus) |-> $past(fcsLoad));
endmodule

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                CRC_W    = 16,
  parameter logic [CRC_W-1:0]  CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF,
  parameter logic [DATA_W-1:0] FLAG_PAT = 8'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              outBit,
  output logic              txd
);
  // the shifter is as wide as the check field; bytes are zero-padded
  localparam int PAD_W = CRC_W - DATA_W;

  logic [DATA_W-1:0] bufReg;
  logic [CRC_W-1:0]  shReg, crcReg, unitWord, crcBase, crcNext;
  logic              feedBack, txdReg;

  always_comb begin
    unitWord = shReg;
    if (strb.loadData)
      unitWord = {{PAD_W{1'b0}}, bufReg};
    else if (strb.loadFcs)
      unitWord = ~crcReg;
    else if (strb.loadFlag)
      unitWord = {{PAD_W{1'b0}}, FLAG_PAT};
    outBit   = strb.emitStuff ? 1'b0 : unitWord[0];
    crcBase  = strb.crcPreset ? CRC_INIT : crcReg;
    feedBack = crcBase[0] ^ outBit;
    crcNext  = (crcBase >> 1) ^ (feedBack ? CRC_POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufReg <= '0;
      shReg  <= '0;
      crcReg <= CRC_INIT;
      txdReg <= 1'b1;
    end else begin
      if (wrEn)
        bufReg <= wrData;
      if (strb.loadData || strb.loadFcs || strb.loadFlag || strb.shiftOut)
        shReg <= unitWord >> 1;
      if (strb.crcStep)
        crcReg <= crcNext;
      if (strb.idleMark)
        txdReg <= 1'b1;
      else if (strb.emitStuff || strb.loadData || strb.loadFcs ||
               strb.loadFlag || strb.shiftOut)
        txdReg <= outBit;
    end
  end

  assign txd = txdReg;

  // R4
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitStuff |=> !txd);
  // R2
  flag_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFlag |=> !txd);
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CRC_W     = 16,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intClr,
  input  logic              txEnable,
  input  logic              autoEnable,
  input  logic              ctsN,
  input  logic              bitEn,
  output logic              txd,
  output logic              bufEmpty,
  output logic              txIntPend,
  output logic              eomStatus
);
  txStrobe_t strb;
  logic      outBit;

  hdlc_tx_ctrl #(.DATA_W(DATA_W), .CRC_W(CRC_W), .STUFF_RUN(STUFF_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .autoEnable(autoEnable),
    .ctsN(ctsN), .bitEn(bitEn), .wrEn(wrEn), .intClr(intClr), .outBit(outBit),
    .strb(strb), .bufEmpty(bufEmpty), .txIntPend(txIntPend), .eomStatus(eomStatus)
  );

  hdlc_tx_dp #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEn(wrEn), .wrData(wrData),
    .outBit(outBit), .txd(txd)
  );

  // R9
  gate_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txEnable && (!autoEnable || !ctsN)) |=> txd);
  // R10
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && txEnable && !autoEnable) |=> $stable(txd));
endmodule

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0, wrEn = 1'b0, intClr = 1'b0;
  logic       txEnable = 1'b0, autoEnable = 1'b0, ctsN = 1'b1, bitEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txd, bufEmpty, txIntPend, eomStatus;

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .intClr(intClr),
    .txEnable(txEnable), .autoEnable(autoEnable), .ctsN(ctsN), .bitEn(bitEn),
    .txd(txd), .bufEmpty(bufEmpty), .txIntPend(txIntPend), .eomStatus(eomStatus)
  );

  int    checks = 0, errors = 0, coinc = 0, stuffed = 0;
  string phase = "R1";
  bit    done = 1'b0;

  // ---------------- behavioural reference ----------------
  bit         q[$];
  bit         qStuffable;
  int         ones;
  bit         inFrame, bufFullM;
  logic [7:0] bufVal;
  logic [15:0] crcM, lastRaw, lastFcs;
  logic       txdE, emptyE, intE, eomE;

  function automatic logic [15:0] crcByte(logic [15:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 16'h8408;
      else             c = c >> 1;
    end
    return c;
  endfunction

  always @(posedge clk) begin
    bit act, ld, b;
    if (!rstN) begin
      q.delete(); ones = 0; inFrame = 0; bufFullM = 0; bufVal = 0;
      crcM = 16'hFFFF; txdE = 1; emptyE = 1; intE = 0; eomE = 0;
    end else begin
      act = txEnable && (!autoEnable || !ctsN);
      ld  = 0;
      if (!act) txdE = 1;
      else if (bitEn) begin
        if (ones == 5) begin
          txdE = 0; ones = 0; stuffed++;
        end else begin
          if (q.size() == 0) begin
            if (bufFullM) begin
              if (!inFrame) begin crcM = 16'hFFFF; eomE = 0; end
              crcM = crcByte(crcM, bufVal);
              for (int i = 0; i < 8; i++) q.push_back(bufVal[i]);
              qStuffable = 1; inFrame = 1; ld = 1;
            end else if (inFrame) begin
              lastRaw = crcM; lastFcs = ~crcM;
              for (int i = 0; i < 16; i++) q.push_back(lastFcs[i]);
              qStuffable = 1; inFrame = 0; eomE = 1;
            end else begin
              for (int i = 0; i < 8; i++) q.push_back(i != 0 && i != 7);
              qStuffable = 0;
            end
          end
          b = q.pop_front();
          txdE = b;
          ones = (qStuffable && b) ? ones + 1 : 0;
        end
      end
      if (ld && wrEn) coinc++;
      if (ld && !wrEn) begin bufFullM = 0; intE = 1; end
      else if (wrEn || intClr) intE = 0;
      if (wrEn) begin bufFullM = 1; bufVal = wrData; end
      emptyE = !bufFullM;
    end
  end

  task automatic chk1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", phase, what, act, exp);
    end
  endtask

  task automatic chkN(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, tagged with the requirement under test
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk1("txd", txd, txdE);
      chk1("bufEmpty", bufEmpty, emptyE);
      chk1("txIntPend", txIntPend, intE);
      chk1("eomStatus", eomStatus, eomE);
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  task automatic writeByte(logic [7:0] b);
    wrEn = 1'b1; wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] data[$]);
    foreach (data[i]) begin
      while (!bufEmpty) @(negedge clk);
      writeByte(data[i]);
    end
  endtask

  task automatic waitEom();
    while (!eomStatus) @(negedge clk);
  endtask

  logic [7:0] got;
  logic [31:0] lfsr = 32'h1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk1("R1 txd", txd, 1'b1);
    chk1("R1 bufEmpty", bufEmpty, 1'b1);
    chk1("R1 txIntPend", txIntPend, 1'b0);
    chk1("R1 eomStatus", eomStatus, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: byte loaded while off replaces the opening flag
    phase = "R3";
    bitEn = 1'b1;
    writeByte(8'hA5);
    repeat (3) @(negedge clk);
    chk1("R9 off keeps byte", bufEmpty, 1'b0);
    txEnable = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); got[i] = txd; end
    chkN("R3 first unit LSB first", {8'h00, got}, 16'h00A5);
    chk1("R7 irq after load", txIntPend, 1'b1);

    // R5 frame close, check residue
    phase = "R5";
    waitEom();
    chkN("R5 residue", crcByte(crcByte(lastRaw, lastFcs[7:0]), lastFcs[15:8]), 16'hF0B8);
    intClr = 1'b1; @(negedge clk); intClr = 1'b0;
    chk1("R7 intClr", txIntPend, 1'b0);

    // R2 idle flags
    phase = "R2";
    repeat (40) @(negedge clk);

    // R4 / R10: ones-heavy frame at half bit rate
    phase = "R4";
    fork
      begin
        for (int i = 0; i < 400; i++) begin bitEn = i[0]; @(negedge clk); end
        bitEn = 1'b1;
      end
      sendFrame('{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8});
    join
    waitEom();
    chkN("R4 zeros inserted", {15'd0, stuffed > 0}, 16'd1);
    phase = "R10";
    repeat (30) @(negedge clk);

    // R6 known check value
    phase = "R6";
    sendFrame('{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39});
    waitEom();
    chkN("R6 check value", lastFcs, 16'h906E);
    repeat (40) @(negedge clk);

    // R8 overwrite while off
    phase = "R8";
    txEnable = 1'b0;
    writeByte(8'h11);
    writeByte(8'h22);
    txEnable = 1'b1;
    while (!bufEmpty) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < 8; i++) begin @(negedge clk); got[i] = txd; end
    chkN("R8 overwritten byte sent", {8'h00, got}, 16'h0022);
    waitEom();
    repeat (30) @(negedge clk);

    // R9 clear-to-send gating
    phase = "R9";
    autoEnable = 1'b1; ctsN = 1'b1;
    writeByte(8'h55);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk1("R9 mark while gated", txd, 1'b1);
      chk1("R9 buffer kept", bufEmpty, 1'b0);
    end
    ctsN = 1'b0;
    waitEom();

    // R7 dense random traffic: coincident write and load
    phase = "R7";
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wrEn   = (lfsr[1:0] == 2'b00);
      wrData = lfsr[15:8];
      intClr = (lfsr[20:17] == 4'h0);
      bitEn  = lfsr[5];
      ctsN   = (lfsr[25:22] == 4'hF);
      txEnable = (lfsr[30:27] != 4'h0);
      @(negedge clk);
    end
    wrEn = 1'b0; intClr = 1'b0;
    chkN("R7 write/load coincidence seen", {15'd0, coinc > 0}, 16'd1);
    finishRun();
  end
endmodule